// File: doc/BRIEF.md
# Two-Clock Line-Doubling Video Scaler

The block sits between a low-resolution raster generator and a VGA-style output. The generator runs on its own clock, a little slower than the output pixel clock, and hands over one pixel per valid strobe, marking the start of each line and frame. The scaler keeps two line stores. The source side fills one while the output side reads the other, so the two clock domains never touch the same line store at once.

On the output side the block produces a standard 640x480 raster (800 clocks by 525 lines, both syncs active low). Each stored source line is shown on two consecutive output lines, and each stored pixel fills two adjacent output columns. A 288-pixel source line therefore covers 576 columns, centred with 32 black columns on each side. The source side marks each completed line by flipping a selector bit. That bit crosses into the output domain through two flops. At the start of each even output line, the reader picks the store that was completed most recently.

All widths and timing figures are parameters. The defaults give a 288-pixel source and 640x480 output.

Top module: `line_doubler_scaler`

## Requirements
- R1: While the output reset is held, `vga_de` is 0, `vga_hsync` and `vga_vsync` are 1, and `vga_rgb` is 0.
- R2: After the output reset is released, the values present after the k-th rising output clock belong to raster position k-1. Position 0 is column 0 of line 0. A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks. `vga_hsync` is 0 exactly for columns H_ACTIVE+H_FP up to H_ACTIVE+H_FP+H_SYNC-1.
- R3: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines. `vga_vsync` is 0 exactly on lines V_ACTIVE+V_FP up to V_ACTIVE+V_FP+V_SYNC-1.
- R4: `vga_de` is 1 exactly when the column is below H_ACTIVE and the line is below V_ACTIVE.
- R5: `vga_rgb` is 0 whenever `vga_de` is 0.
- R6: In the active area, columns below (H_ACTIVE-2*SRC_W)/2 and columns at or above that margin plus 2*SRC_W are black (0).
- R7: Inside the image window, output column c shows stored pixel (c - margin)/2, rounded down.
- R8: Output lines 2k and 2k+1 show the same stored line. That line is the one most recently completed before the end of output line 2k-1.
- R9: A `src_line_start` or `src_frame_start` pulse sets the write column to 0. Each cycle with `src_valid` high stores `src_pix` at the next column. Cycles with `src_valid` low store nothing.
- R10: Valid pixels beyond SRC_W on one line are dropped. They do not change any displayed pixel.
- R11: A line that ends before SRC_W valid pixels does not count as completed. The display keeps showing the previous completed line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source generator clock |
| src_rst_n | input | 1 | Active-low asynchronous reset, source domain |
| src_pix | input | PIX_W | Source pixel colour |
| src_valid | input | 1 | Source pixel strobe |
| src_line_start | input | 1 | Start of a source line, clears the write column |
| src_frame_start | input | 1 | Start of a source frame, also clears the write column |
| vga_clk | input | 1 | Output pixel clock |
| vga_rst_n | input | 1 | Active-low asynchronous reset, output domain |
| vga_rgb | output | PIX_W | Output colour, black outside the image window |
| vga_hsync | output | 1 | Horizontal sync, active low |
| vga_vsync | output | 1 | Vertical sync, active low |
| vga_de | output | 1 | High in the visible area |

## Verification
The bench feeds lines whose spacing shifts at random, with idle gaps in which garbage sits on the pixel input. If the design latched pixels during those gaps, the image would show shifted or foreign colours. It also sends lines with extra pixels after the last column. A design that let the write column run on would overwrite the store being displayed, or flip the selector early. Aborted short lines check that a design which counts any line end as completion does not show half-written data. A line opened by the frame pulse instead of the line pulse checks the reset of the column. Every output pixel is compared with the 2x2 expansion of the source line expected at that moment. Errors in border width, column halving, or the even/odd line pairing show up as wrong colours at exact positions.

// File: rtl/line_doubler_scaler.sv
module line_doubler_scaler #(
  parameter int PIX_W    = 12,
  parameter int SRC_W    = 288,
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic [PIX_W-1:0] src_pix,
  input  logic             src_valid,
  input  logic             src_line_start,
  input  logic             src_frame_start,
  input  logic             vga_clk,
  input  logic             vga_rst_n,
  output logic [PIX_W-1:0] vga_rgb,
  output logic             vga_hsync,
  output logic             vga_vsync,
  output logic             vga_de
);

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int MARGIN  = (H_ACTIVE - 2 * SRC_W) / 2;
  localparam int DEPTH   = 2 * SRC_W;
  localparam int XW      = $clog2(SRC_W + 1);
  localparam int AW      = $clog2(DEPTH);
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT   = HW'(H_ACTIVE);
  localparam logic [HW-1:0] HS_BEG  = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_END  = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [HW-1:0] IMG_BEG = HW'(MARGIN);
  localparam logic [HW-1:0] IMG_END = HW'(MARGIN + 2 * SRC_W);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_ACT   = VW'(V_ACTIVE);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_END  = VW'(V_ACTIVE + V_FP + V_SYNC);
  localparam logic [XW-1:0] X_LAST  = XW'(SRC_W - 1);
  localparam logic [AW-1:0] B1_BASE = AW'(SRC_W);

  logic [PIX_W-1:0] mem [DEPTH];

  // ---------------- source domain: fill one store while the other is shown
  logic [XW-1:0] wr_x;
  logic [XW-1:0] col;
  logic          wr_sel;
  logic          wr_en;
  logic [AW-1:0] wr_addr;

  assign col     = (src_line_start || src_frame_start) ? '0 : wr_x;
  assign wr_en   = src_valid && (col <= X_LAST);
  assign wr_addr = AW'(col) + (wr_sel ? B1_BASE : '0);

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      wr_x   <= '0;
      wr_sel <= 1'b0;
    end else begin
      wr_x <= col;
      if (wr_en) begin
        wr_x <= col + XW'(1);
        if (col == X_LAST) wr_sel <= ~wr_sel;
      end
    end
  end

  always_ff @(posedge src_clk) begin
    if (wr_en) mem[wr_addr] <= src_pix;
  end

  // ---------------- output domain: raster counters and doubled readout
  logic [HW-1:0]    h, h_nx, h_off;
  logic [VW-1:0]    v, v_nx;
  logic             sel_s1, sel_s2, rd_buf;
  logic             in_img;
  logic [AW-1:0]    rd_addr;
  logic [PIX_W-1:0] rd_q;
  logic             de_q, hs_q, vs_q, img_q;

  assign h_nx    = (h == H_LAST) ? '0 : h + HW'(1);
  assign v_nx    = (v == V_LAST) ? '0 : v + VW'(1);
  assign in_img  = (v < V_ACT) && (h >= IMG_BEG) && (h < IMG_END);
  assign h_off   = h - IMG_BEG;
  assign rd_addr = AW'(h_off >> 1) + (rd_buf ? B1_BASE : '0);

  always_ff @(posedge vga_clk or negedge vga_rst_n) begin
    if (!vga_rst_n) begin
      h      <= '0;
      v      <= '0;
      sel_s1 <= 1'b0;
      sel_s2 <= 1'b0;
      rd_buf <= 1'b1;
      de_q   <= 1'b0;
      hs_q   <= 1'b1;
      vs_q   <= 1'b1;
      img_q  <= 1'b0;
    end else begin
      h      <= h_nx;
      sel_s1 <= wr_sel;
      sel_s2 <= sel_s1;
      if (h == H_LAST) begin
        v <= v_nx;
        if (!v_nx[0]) rd_buf <= ~sel_s2;
      end
      de_q  <= (h < H_ACT) && (v < V_ACT);
      hs_q  <= !((h >= HS_BEG) && (h < HS_END));
      vs_q  <= !((v >= VS_BEG) && (v < VS_END));
      img_q <= in_img;
    end
  end

  always_ff @(posedge vga_clk) begin
    if (in_img) rd_q <= mem[rd_addr];
  end

  assign vga_rgb   = img_q ? rd_q : '0;
  assign vga_de    = de_q;
  assign vga_hsync = hs_q;
  assign vga_vsync = vs_q;

  // ---------------- checks
  assert_blank_black_R5: assert property (@(posedge vga_clk) disable iff (!vga_rst_n)
    !vga_de |-> (vga_rgb == '0));

  assert_no_sync_in_view_R4: assert property (@(posedge vga_clk) disable iff (!vga_rst_n)
    vga_de |-> (vga_hsync && vga_vsync));

  assert_store_swap_at_pair_R8: assert property (@(posedge vga_clk) disable iff (!vga_rst_n)
    (rd_buf != $past(rd_buf)) |-> (h == '0 && !v[0]));

  assert_col_bounded_R10: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    wr_x <= XW'(SRC_W));

  assert_flip_only_on_full_R11: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (wr_sel != $past(wr_sel)) |-> ($past(src_valid) && $past(col) == X_LAST));

endmodule

// File: tb/line_doubler_scaler_test.sv
module line_doubler_scaler_test;

  localparam int PIX_W    = 12;
  localparam int SRC_W    = 8;
  localparam int H_ACTIVE = 24;
  localparam int H_FP     = 4;
  localparam int H_SYNC   = 6;
  localparam int H_BP     = 6;
  localparam int V_ACTIVE = 8;
  localparam int V_FP     = 1;
  localparam int V_SYNC   = 2;
  localparam int V_BP     = 3;
  localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int MARGIN   = (H_ACTIVE - 2 * SRC_W) / 2;
  localparam int RUN      = 8 * H_TOTAL * V_TOTAL;

  logic             src_clk = 1'b0, src_rst_n = 1'b0;
  logic [PIX_W-1:0] src_pix;
  logic             src_valid, src_line_start, src_frame_start;
  logic             vga_clk = 1'b0, vga_rst_n = 1'b0;
  logic [PIX_W-1:0] vga_rgb;
  logic             vga_hsync, vga_vsync, vga_de;

  line_doubler_scaler #(
    .PIX_W(PIX_W), .SRC_W(SRC_W), .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC),
    .H_BP(H_BP), .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) uut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_pix(src_pix), .src_valid(src_valid),
    .src_line_start(src_line_start), .src_frame_start(src_frame_start),
    .vga_clk(vga_clk), .vga_rst_n(vga_rst_n), .vga_rgb(vga_rgb),
    .vga_hsync(vga_hsync), .vga_vsync(vga_vsync), .vga_de(vga_de)
  );

  always #10 vga_clk = ~vga_clk;
  always #11 src_clk = ~src_clk;

  int checks = 0, fails = 0, img_checks = 0;
  int pos = 0, h = 0, v = 0, ep = 0, mode = 0, n = 0;
  bit done = 1'b0, last_ok = 1'b0, shown_ok = 1'b0;
  string last_tag = "R9", shown_tag = "R9";
  logic [PIX_W-1:0] nl [SRC_W];
  logic [PIX_W-1:0] last [SRC_W];
  logic [PIX_W-1:0] shown [SRC_W];
  event go;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (col %0d line %0d)", req, act, exp, h, v);
    end
  endtask

  function automatic bit exp_hs(int c);
    return !(c >= H_ACTIVE + H_FP && c < H_ACTIVE + H_FP + H_SYNC);
  endfunction

  function automatic bit exp_vs(int l);
    return !(l >= V_ACTIVE + V_FP && l < V_ACTIVE + V_FP + V_SYNC);
  endfunction

  function automatic bit exp_de(int c, int l);
    return (c < H_ACTIVE) && (l < V_ACTIVE);
  endfunction

  function automatic bit in_window(int c);
    return (c >= MARGIN) && (c < MARGIN + 2 * SRC_W);
  endfunction

  always @(negedge vga_clk) begin
    if (!vga_rst_n) begin
      chk(vga_de === 1'b0, "R1 de", 32'(vga_de), 0);
      chk(vga_hsync === 1'b1 && vga_vsync === 1'b1, "R1 syncs", {vga_hsync, vga_vsync}, 3);
      chk(vga_rgb === '0, "R1 rgb", 32'(vga_rgb), 0);
    end else if (!done) begin
      h = pos % H_TOTAL;
      v = (pos / H_TOTAL) % V_TOTAL;
      if (h == 0 && v % 2 == 0) begin
        shown = last;
        shown_ok = last_ok;
        shown_tag = last_tag;
        ->go;
      end
      chk(vga_hsync === exp_hs(h), "R2 hsync", 32'(vga_hsync), 32'(exp_hs(h)));
      chk(vga_vsync === exp_vs(v), "R3 vsync", 32'(vga_vsync), 32'(exp_vs(v)));
      chk(vga_de === exp_de(h, v), "R4 de", 32'(vga_de), 32'(exp_de(h, v)));
      if (!exp_de(h, v))
        chk(vga_rgb === '0, "R5 blank", 32'(vga_rgb), 0);
      else if (!in_window(h))
        chk(vga_rgb === '0, "R6 border", 32'(vga_rgb), 0);
      else if (shown_ok) begin
        img_checks++;
        chk(vga_rgb === shown[(h - MARGIN) / 2],
            (v % 2 == 0) ? {"R7/", shown_tag} : {"R8/", shown_tag},
            32'(vga_rgb), 32'(shown[(h - MARGIN) / 2]));
      end
      pos++;
    end
  end

  // source writer: one episode per output line pair; first five episodes directed
  initial begin
    void'($urandom(32'h5eed));
    src_pix = '0; src_valid = 1'b0; src_line_start = 1'b0; src_frame_start = 1'b0;
    forever begin
      @(go);
      mode = (ep < 5) ? ep : int'($urandom % 5);
      ep++;
      if (mode != 4) begin
        @(negedge src_clk);
        if (mode == 3) src_frame_start = 1'b1; else src_line_start = 1'b1;
        @(negedge src_clk);
        src_line_start = 1'b0; src_frame_start = 1'b0;
        n = (mode == 2) ? 3 : (mode == 1) ? SRC_W + 2 : SRC_W;
        for (int i = 0; i < n; i++) begin
          repeat (3 + $urandom % 3) begin
            @(negedge src_clk);
            src_pix = PIX_W'($urandom);
          end
          src_valid = 1'b1;
          src_pix = PIX_W'($urandom);
          if (i < SRC_W) nl[i] = src_pix;
          @(negedge src_clk);
          src_valid = 1'b0;
        end
        if (mode == 2) last_tag = "R11";
        else begin
          last = nl;
          last_ok = 1'b1;
          last_tag = (mode == 1) ? "R10" : "R9";
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge src_clk);
    #3 src_rst_n = 1'b1;
    repeat (4) @(negedge vga_clk);
    #3 vga_rst_n = 1'b1;
    wait (pos >= RUN);
    done = 1'b1;
    chk(img_checks > 0, "R8 image compared", 32'(img_checks), 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (RUN + 2000) @(posedge vga_clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d positions expected %0d", pos, RUN);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule